// File: doc/BRIEF.md
# Floppy Controller Register and Interrupt Core

This block is the byte-wide register file that sits between a processor bus and a floppy drive's mechanics. A plain bus of address, write strobe, read strobe and 8-bit data reaches sixteen registers spaced 16 bytes apart. Software drives the controller through a control byte that has no direct write port: one address clears the bits written as ones, a neighbouring address sets them. The same neighbouring address, when read, returns a status byte rather than the control byte.

The block holds a microsecond down-counter, a seek step counter that issues step pulses and counts itself down, and a latched cause register with a matching enable register. One interrupt line rises when the global enable bit in control is set and an enabled cause is pending. Sector transfer, data separation and DMA live elsewhere; their events arrive on input pins and are latched here.

The register index is taken from address bits [STRIDE_LOG2+3:STRIDE_LOG2]; the low address bits are ignored. Index map: 0 data byte, 1 microsecond counter, 2 fault flags, 3 mode, 4 line select, 5 config, 6 control (write clears, read returns control), 7 control-set on write / status on read, 8 cause, 9 step count, 10 current track, 11 current sector, 12 gap length, 13 target sector, 14 sector count, 15 cause enable.

Top module: `fdc_regcore`

## Requirements
- R1: After reset every register reads 0x00, and irq and step_out are low.
- R2: Registers 0, 3, 4, 5, 10, 11, 12, 13, 14 and 15 are plain storage: a write stores the byte and a read returns it, whatever the low STRIDE_LOG2 address bits are.
- R3: A write to index 6 clears each control bit written as 1; a write to index 7 sets each control bit written as 1; a read of index 6 returns control. Control bit 7 starts a seek, bit 0 is the global interrupt enable.
- R4: A read of index 7 returns status: bit 7 FIFO-one, bit 6 FIFO-two, bit 5 any fault flag pending, bit 4 zero, bit 3 drive sense, bit 2 read-data bit, bit 1 interrupt pending, bit 0 mark byte.
- R5: Cause bits (index 8, enable at index 15) are timer-done 0x01, seek-done 0x02, seen-sector 0x04, transfer-done 0x08, data-changed 0x10, fault 0x20. Events OR into the latch; a read of index 8 returns the latch and clears it, keeping only events arriving on that same cycle.
- R6: irq is high exactly when control bit 0 is set and cause AND cause-enable is nonzero; status bit 1 equals irq.
- R7: The fault register (index 2) collects err_bits as data-CRC 0x80, address-CRC 0x40, overrun 0x04, underrun 0x01; any of them also latches cause 0x20; reading index 2 clears it.
- R8: A write to index 1 loads the counter, which then drops by one every CLK_PER_US clocks and stops at zero; cause 0x01 latches on the clock edge where it reaches zero (edge T*CLK_PER_US after the load edge).
- R9: While control bit 7 is set and the step count (index 9) is nonzero, step_out gives one pulse STEP_W clocks wide every STEP_GAP clocks, the count drops by one per step, and cause 0x02 latches on the edge where it reaches zero (N*STEP_GAP edges after the start for count N).
- R10: step_dir takes dir_in on a clock where dir_load is high and holds otherwise.
- R11: While config bit 7 is set, control, cause, fault, step count and the microsecond counter are cleared on each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clear-on-read acts at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, zero otherwise |
| dir_in | input | 1 | Step direction from the drive command side |
| dir_load | input | 1 | Latch enable for dir_in |
| step_out | output | 1 | Step pulse to the drive |
| step_dir | output | 1 | Latched step direction |
| ev_seen_sec | input | 1 | Seen-sector event |
| ev_xfer_done | input | 1 | Transfer-done event |
| ev_data_chg | input | 1 | Data-changed event |
| err_bits | input | 4 | Fault events: [3] data CRC, [2] address CRC, [1] overrun, [0] underrun |
| st_fifo_one | input | 1 | FIFO holds one byte |
| st_fifo_two | input | 1 | FIFO holds two bytes |
| st_sense | input | 1 | Drive sense line |
| st_rd_bit | input | 1 | Raw read-data bit |
| st_mark | input | 1 | Mark byte seen |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CLK_PER_US of 4, STEP_GAP of 6 and STEP_W of 2, so a microsecond is four clocks and a step is six. With those values the exact edge of timer expiry and seek completion sits a few dozen cycles out, every control byte value can be set and cleared in turn, and all 64 cause-enable masks can be crossed with a fixed cause pattern, and seeks of one to four steps fit in a short run.

// File: rtl/fdc_regcore_pkg.sv
package fdc_regcore_pkg;
   localparam int BYTE_W   = 8;
   localparam int NUM_REGS = 16;
   localparam int IDX_W    = $clog2(NUM_REGS);
   localparam int CAUSE_W  = 6;
   localparam int FAULT_W  = 4;

   typedef enum logic [IDX_W-1:0] {
      RG_BYTE      = 4'd0,
      RG_USCNT     = 4'd1,
      RG_FAULT     = 4'd2,
      RG_MODE      = 4'd3,
      RG_LINESEL   = 4'd4,
      RG_CONFIG    = 4'd5,
      RG_CTLCLR    = 4'd6,
      RG_CTLSET    = 4'd7,
      RG_CAUSE     = 4'd8,
      RG_STEPS     = 4'd9,
      RG_CURTRK    = 4'd10,
      RG_CURSEC    = 4'd11,
      RG_GAPLEN    = 4'd12,
      RG_TGTSEC    = 4'd13,
      RG_SECCNT    = 4'd14,
      RG_CAUSE_EN  = 4'd15
   } reg_idx_e;

   // cause bit positions
   localparam int CB_TIMER = 0;
   localparam int CB_SEEK  = 1;
   localparam int CB_SEEN  = 2;
   localparam int CB_XFER  = 3;
   localparam int CB_DCHG  = 4;
   localparam int CB_FAULT = 5;

   // control bit positions
   localparam int CTL_IRQ_EN  = 0;
   localparam int CTL_SEEK_GO = 7;

   // config bit that holds the soft reset
   localparam int CFG_SOFT_RST = 7;

   function automatic logic is_plain(input int i);
      return !(i == int'(RG_USCNT) || i == int'(RG_FAULT) || i == int'(RG_CTLCLR) ||
               i == int'(RG_CTLSET) || i == int'(RG_CAUSE) || i == int'(RG_STEPS));
   endfunction
endpackage

// File: rtl/fdc_us_timer.sv
module fdc_us_timer #(
   parameter int W          = 8,
   parameter int CLK_PER_US = 100
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         done
);
   logic tick;

   generate
      if (CLK_PER_US == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(CLK_PER_US);
         localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           pre_q <= '0;
            else if (clr || load || pre_q == PRE_LAST) pre_q <= '0;
            else                                  pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (clr)                 count <= '0;
      else if (load)                count <= load_val;
      else if (tick && count != '0) count <= count - 1'b1;
   end

   assign done = tick && !clr && !load && (count == W'(1));
endmodule

// File: rtl/fdc_step_engine.sv
module fdc_step_engine #(
   parameter int W        = 8,
   parameter int STEP_GAP = 300,
   parameter int STEP_W   = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         go,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] steps,
   output logic         step_pulse,
   output logic         done
);
   localparam int GW = $clog2(STEP_GAP);
   localparam logic [GW-1:0] GAP_LAST = GW'(STEP_GAP - 1);
   localparam logic [GW-1:0] HI_LEN   = GW'(STEP_W);

   logic [GW-1:0] cnt_q;
   logic          active;
   logic          step_end;

   assign active   = go && (steps != '0);
   assign step_end = active && !load && !clr && (cnt_q == GAP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (clr || load || !active)     cnt_q <= '0;
      else if (cnt_q == GAP_LAST)          cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        steps <= '0;
      else if (clr)      steps <= '0;
      else if (load)     steps <= load_val;
      else if (step_end) steps <= steps - 1'b1;
   end

   assign step_pulse = active && (cnt_q < HI_LEN);
   assign done       = step_end && (steps == W'(1));
endmodule

// File: rtl/fdc_cause_latch.sv
module fdc_cause_latch #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ack,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] mask,
   input  logic         gate,
   output logic [N-1:0] cause,
   output logic         pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cause <= '0;
      else if (clr) cause <= '0;
      else if (ack) cause <= ev;
      else          cause <= cause | ev;
   end

   assign pend = gate && ((cause & mask) != '0);
endmodule

// File: rtl/fdc_regcore.sv
module fdc_regcore
   import fdc_regcore_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int STRIDE_LOG2 = 4,
   parameter int CLK_PER_US  = 100,
   parameter int STEP_GAP    = 300,
   parameter int STEP_W      = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              dir_in,
   input  logic              dir_load,
   output logic              step_out,
   output logic              step_dir,
   input  logic              ev_seen_sec,
   input  logic              ev_xfer_done,
   input  logic              ev_data_chg,
   input  logic [3:0]        err_bits,
   input  logic              st_fifo_one,
   input  logic              st_fifo_two,
   input  logic              st_sense,
   input  logic              st_rd_bit,
   input  logic              st_mark,
   output logic              irq
);
   generate
      if (ADDR_W < STRIDE_LOG2 + IDX_W) begin : g_bad_addr
         $error("ADDR_W too small for sixteen registers at the chosen stride");
      end
      if (STEP_W < 1 || STEP_W >= STEP_GAP) begin : g_bad_step
         $error("STEP_W must be at least 1 and below STEP_GAP");
      end
      if (CLK_PER_US < 1) begin : g_bad_us
         $error("CLK_PER_US must be at least 1");
      end
   endgenerate

   reg_idx_e            idx;
   logic [BYTE_W-1:0]   plain_q [NUM_REGS];
   logic [BYTE_W-1:0]   ctrl_q;
   logic [FAULT_W-1:0]  err_q;
   logic [BYTE_W-1:0]   timer_q;
   logic [BYTE_W-1:0]   steps_q;
   logic [CAUSE_W-1:0]  cause_q;
   logic [CAUSE_W-1:0]  ev_vec;
   logic                soft_rst;
   logic                tmr_done;
   logic                seek_done;
   logic                pend;
   logic                dir_q;
   logic [BYTE_W-1:0]   status_b;
   logic [BYTE_W-1:0]   fault_b;
   logic [BYTE_W-1:0]   rd_mux;
   logic                unused_addr;

   assign idx         = reg_idx_e'(bus_addr[STRIDE_LOG2 +: IDX_W]);
   assign unused_addr = ^bus_addr;
   assign soft_rst    = plain_q[int'(RG_CONFIG)][CFG_SOFT_RST];

   // plain storage registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) plain_q[i] <= '0;
      end else if (bus_wr && is_plain(int'(idx))) begin
         plain_q[idx] <= bus_wdata;
      end
   end

   // control: clear-by-ones at one index, set-by-ones at the next
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ctrl_q <= '0;
      else if (soft_rst)                    ctrl_q <= '0;
      else if (bus_wr && idx == RG_CTLCLR)  ctrl_q <= ctrl_q & ~bus_wdata;
      else if (bus_wr && idx == RG_CTLSET)  ctrl_q <= ctrl_q | bus_wdata;
   end

   // fault flags: accumulate, clear on read keeping same-cycle events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          err_q <= '0;
      else if (soft_rst)                   err_q <= '0;
      else if (bus_rd && idx == RG_FAULT)  err_q <= err_bits;
      else                                 err_q <= err_q | err_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dir_q <= 1'b0;
      else if (dir_load) dir_q <= dir_in;
   end
   assign step_dir = dir_q;

   fdc_us_timer #(
      .W          (BYTE_W),
      .CLK_PER_US (CLK_PER_US)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .load     (bus_wr && idx == RG_USCNT),
      .load_val (bus_wdata),
      .count    (timer_q),
      .done     (tmr_done)
   );

   fdc_step_engine #(
      .W        (BYTE_W),
      .STEP_GAP (STEP_GAP),
      .STEP_W   (STEP_W)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_rst),
      .go         (ctrl_q[CTL_SEEK_GO]),
      .load       (bus_wr && idx == RG_STEPS),
      .load_val   (bus_wdata),
      .steps      (steps_q),
      .step_pulse (step_out),
      .done       (seek_done)
   );

   always_comb begin
      ev_vec           = '0;
      ev_vec[CB_TIMER] = tmr_done;
      ev_vec[CB_SEEK]  = seek_done;
      ev_vec[CB_SEEN]  = ev_seen_sec;
      ev_vec[CB_XFER]  = ev_xfer_done;
      ev_vec[CB_DCHG]  = ev_data_chg;
      ev_vec[CB_FAULT] = |err_bits;
   end

   fdc_cause_latch #(
      .N (CAUSE_W)
   ) u_cause (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .ack   (bus_rd && idx == RG_CAUSE),
      .ev    (ev_vec),
      .mask  (plain_q[int'(RG_CAUSE_EN)][CAUSE_W-1:0]),
      .gate  (ctrl_q[CTL_IRQ_EN]),
      .cause (cause_q),
      .pend  (pend)
   );
   assign irq = pend;

   assign status_b = {st_fifo_one, st_fifo_two, |err_q, 1'b0,
                      st_sense, st_rd_bit, pend, st_mark};
   assign fault_b  = {err_q[3], err_q[2], 3'b000, err_q[1], 1'b0, err_q[0]};

   always_comb begin
      unique case (idx)
         RG_USCNT: rd_mux = timer_q;
         RG_FAULT: rd_mux = fault_b;
         RG_CTLCLR: rd_mux = ctrl_q;
         RG_CTLSET: rd_mux = status_b;
         RG_CAUSE: rd_mux = {{(BYTE_W-CAUSE_W){1'b0}}, cause_q};
         RG_STEPS: rd_mux = steps_q;
         default:  rd_mux = plain_q[idx];
      endcase
   end

   assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/fdc_regcore_chk.sv
module fdc_regcore_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] idx,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic [7:0] bus_wdata,
   input logic [7:0] ctrl_q,
   input logic [5:0] cause_q,
   input logic [5:0] ev_vec,
   input logic [3:0] err_q,
   input logic [7:0] steps_q,
   input logic [7:0] timer_q,
   input logic       soft_rst,
   input logic       step_out,
   input logic       irq
);
   assert_ctrl_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && idx == 4'd7 && !soft_rst) |=> ((ctrl_q & $past(bus_wdata)) == $past(bus_wdata)));

   assert_ctrl_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && idx == 4'd6 && !soft_rst) |=> ((ctrl_q & $past(bus_wdata)) == 8'h00));

   assert_cause_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && idx == 4'd8 && ev_vec == 6'd0) |=> (cause_q == 6'd0));

   assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(ev_vec) != 6'd0 || $past(bus_wr)));

   assert_step_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step_out |-> (steps_q != 8'd0));

   assert_steps_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && idx == 4'd9) |=> (steps_q <= $past(steps_q)));

   assert_timer_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && idx == 4'd1) |=> (timer_q <= $past(timer_q)));

   assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_q == 8'h00 && cause_q == 6'd0 && err_q == 4'd0 &&
                    steps_q == 8'd0 && timer_q == 8'd0));
endmodule

bind fdc_regcore fdc_regcore_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .idx       (idx),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .ctrl_q    (ctrl_q),
   .cause_q   (cause_q),
   .ev_vec    (ev_vec),
   .err_q     (err_q),
   .steps_q   (steps_q),
   .timer_q   (timer_q),
   .soft_rst  (soft_rst),
   .step_out  (step_out),
   .irq       (irq)
);

// File: tb/fdc_regcore_bench.sv
module fdc_regcore_bench;
   localparam int US   = 4;
   localparam int GAP  = 6;
   localparam int HI   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       dir_in = 1'b0;
   logic       dir_load = 1'b0;
   logic       step_out;
   logic       step_dir;
   logic       ev_seen_sec = 1'b0;
   logic       ev_xfer_done = 1'b0;
   logic       ev_data_chg = 1'b0;
   logic [3:0] err_bits = '0;
   logic       st_fifo_one = 1'b0;
   logic       st_fifo_two = 1'b0;
   logic       st_sense = 1'b0;
   logic       st_rd_bit = 1'b0;
   logic       st_mark = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   fdc_regcore #(
      .ADDR_W(8), .STRIDE_LOG2(4), .CLK_PER_US(US), .STEP_GAP(GAP), .STEP_W(HI)
   ) u_fdc_regcore (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dir_in(dir_in), .dir_load(dir_load),
      .step_out(step_out), .step_dir(step_dir), .ev_seen_sec(ev_seen_sec),
      .ev_xfer_done(ev_xfer_done), .ev_data_chg(ev_data_chg), .err_bits(err_bits),
      .st_fifo_one(st_fifo_one), .st_fifo_two(st_fifo_two), .st_sense(st_sense),
      .st_rd_bit(st_rd_bit), .st_mark(st_mark), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int i, input logic [7:0] v, input logic [3:0] lo = 4'h0);
      @(negedge clk);
      bus_addr = {4'(i), lo}; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int i, output logic [7:0] v, input logic [3:0] lo = 4'h0);
      @(negedge clk);
      bus_addr = {4'(i), lo}; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1;
      chk("R1 irq", irq, 0);
      chk("R1 step_out", step_out, 0);
      for (int i = 0; i < 16; i++) begin
         rd(i, v);
         chk($sformatf("R1 reg %0d", i), v, 0);
      end

      // R2: plain registers with varied low address bits
      for (int i = 0; i < 16; i++) begin
         if (i == 0 || i == 3 || i == 4 || i == 5 || (i >= 10)) begin
            logic [7:0] pat;
            pat = 8'((i * 37 + 11) ^ 8'h5A);
            if (i == 5) pat = pat & 8'h7F;
            wr(i, pat, 4'(i));
            rd(i, v, 4'hF);
            chk($sformatf("R2 reg %0d", i), v, pat);
         end
      end
      for (int x = 0; x < 256; x++) begin
         wr(12, 8'(x));
         rd(12, v, 4'h7);
         chk("R2 gap sweep", v, x);
      end
      wr(15, 8'h00);

      // R3: set and clear control by ones
      for (int x = 0; x < 256; x++) begin
         logic [7:0] m;
         m = 8'(x) ^ 8'hA5;
         wr(6, 8'hFF);
         wr(7, 8'(x));
         rd(6, v);
         chk("R3 set", v, x);
         wr(6, m);
         rd(6, v);
         chk("R3 clear", v, 8'(x) & ~m);
      end
      wr(6, 8'hFF);

      // R4: status assembly from stub pins
      for (int s = 0; s < 32; s++) begin
         @(negedge clk);
         {st_fifo_one, st_fifo_two, st_sense, st_rd_bit, st_mark} = 5'(s);
         rd(7, v);
         chk("R4 status", v, {s[4], s[3], 2'b00, s[2], s[1], 1'b0, s[0]});
      end
      {st_fifo_one, st_fifo_two, st_sense, st_rd_bit, st_mark} = 5'd0;

      // R5/R6: latch, mask, global enable
      wr(7, 8'h01);
      for (int m = 0; m < 64; m++) begin
         wr(15, 8'(m));
         @(negedge clk);
         ev_seen_sec = 1'b1; ev_xfer_done = 1'b1; ev_data_chg = 1'b1;
         @(negedge clk);
         ev_seen_sec = 1'b0; ev_xfer_done = 1'b0; ev_data_chg = 1'b0;
         chk("R6 irq mask", irq, (m & 8'h1C) != 0);
         rd(7, v);
         chk("R6 status pending", v[1], (m & 8'h1C) != 0);
         rd(8, v);
         chk("R5 cause read", v, 8'h1C);
         #1 chk("R6 irq after clear", irq, 0);
      end
      wr(15, 8'h04);
      @(negedge clk); ev_seen_sec = 1'b1;
      @(negedge clk); ev_seen_sec = 1'b0;
      wr(6, 8'h01);
      chk("R6 gate off", irq, 0);
      wr(7, 8'h01);
      chk("R6 gate on", irq, 1);
      // event arriving on the clearing read is kept
      @(negedge clk);
      bus_addr = 8'h80; bus_rd = 1'b1; ev_xfer_done = 1'b1;
      #1 chk("R5 read value", bus_rdata, 8'h04);
      @(negedge clk);
      bus_rd = 1'b0; ev_xfer_done = 1'b0;
      rd(8, v);
      chk("R5 same-cycle event kept", v, 8'h08);

      // R7: fault flags
      @(negedge clk); err_bits = 4'b1010;
      @(negedge clk); err_bits = 4'b0000;
      rd(7, v);
      chk("R7 status fault", v[5], 1);
      rd(2, v);
      chk("R7 fault value", v, 8'h84);
      rd(2, v);
      chk("R7 fault cleared", v, 8'h00);
      rd(8, v);
      chk("R7 fault cause", v, 8'h20);
      @(negedge clk); err_bits = 4'b0101;
      @(negedge clk); err_bits = 4'b0000;
      rd(2, v);
      chk("R7 fault value 2", v, 8'h41);

      // R8: microsecond counter expiry edge
      for (int t = 1; t <= 6; t += 5) begin
         wr(15, 8'h01);
         rd(8, v);
         wr(1, 8'(t));
         repeat (t * US - 1) @(negedge clk);
         chk("R8 before expiry", irq, 0);
         @(negedge clk);
         chk("R8 at expiry", irq, 1);
         rd(1, v);
         chk("R8 counter zero", v, 0);
         repeat (3 * US) @(negedge clk);
         rd(1, v);
         chk("R8 stays zero", v, 0);
         rd(8, v);
         chk("R8 cause bit", v, 8'h01);
      end
      wr(1, 8'd10);
      repeat (2 * US) @(negedge clk);
      rd(1, v);
      chk("R8 mid count", v, 8);

      // R10 and R9: direction latch and seeks of 1..4 steps
      for (int n = 1; n <= 4; n++) begin
         int rises;
         int highs;
         logic prev;
         @(negedge clk); dir_in = n[0]; dir_load = 1'b1;
         @(negedge clk); dir_load = 1'b0; dir_in = ~n[0];
         @(negedge clk);
         chk("R10 dir latched", step_dir, n[0]);
         wr(15, 8'h02);
         rd(8, v);
         wr(9, 8'(n));
         wr(7, 8'h81);
         prev = 1'b0; rises = 0; highs = 0;
         if (step_out) begin rises++; highs++; end
         prev = step_out;
         for (int c = 1; c <= n * GAP + 3; c++) begin
            @(negedge clk);
            if (step_out && !prev) rises++;
            if (step_out) highs++;
            prev = step_out;
            if (c == n * GAP - 1) chk("R9 before done", irq, 0);
            if (c == n * GAP)     chk("R9 done edge", irq, 1);
         end
         chk("R9 pulse count", rises, n);
         chk("R9 pulse width", highs, n * HI);
         rd(9, v);
         chk("R9 count zero", v, 0);
         rd(8, v);
         chk("R9 cause", v, 8'h02);
         wr(6, 8'h80);
      end

      // R11: soft reset via config bit 7
      wr(7, 8'h83);
      wr(9, 8'd3);
      wr(1, 8'd50);
      @(negedge clk); err_bits = 4'b0001; ev_seen_sec = 1'b1;
      @(negedge clk); err_bits = 4'b0000; ev_seen_sec = 1'b0;
      wr(5, 8'h80);
      rd(6, v);  chk("R11 control", v, 0);
      rd(8, v);  chk("R11 cause", v, 0);
      rd(2, v);  chk("R11 fault", v, 0);
      rd(9, v);  chk("R11 steps", v, 0);
      rd(1, v);  chk("R11 timer", v, 0);
      wr(7, 8'h01);
      rd(6, v);  chk("R11 held", v, 0);
      wr(5, 8'h00);
      wr(7, 8'h01);
      rd(6, v);  chk("R11 released", v, 8'h01);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule